// File: doc/BRIEF.md
# Field-Stop Command Receiver

This block turns a reader's on/off keying of the RF field into decoded commands. It has two inputs. One is a free-running tick, one pulse per RF period. The other says whether the field is present on that period. When the field has been absent for a few consecutive ticks, the block declares a field stop. The first stop seen while idle suspends the normal reply stream and starts a receive session. From then on, time is cut into 32-period bit slots. The first half of each slot keeps the modulator released and the second half engages it, and a bit reads as 0 when a field stop lands anywhere inside the slot.

A session has a fixed layout. It opens with a start bit that must be 0. Next comes a three-bit command code with even parity. The code decides what follows: an address field, a 45-bit data matrix with row and column parity, or both. Each session ends in one of two ways. It may produce one decoded command with its address, its 32-bit data and a parity-error flag, which the controller uses to choose between a normal reply and an error reply. Or, on a bad start bit or a bad or unknown code, it produces a silent drop. The RF tick must be at least two clock cycles apart.

Top module: `fsr_cmd_rx`

## Requirements
- R1: A field stop is declared on the RF tick at which the field has been absent for STOP_TICKS (default 5) consecutive ticks. A shorter absence has no effect, and a stop is reported only once per absence.
- R2: After the first stop, slot 0 begins on the first tick with the field back. Each slot is SLOT_TICKS (32) periods long. `mod_on` is high during periods 16..31 of a slot and low during periods 0..15 and whenever no session runs.
- R3: `busy` rises when a field stop is detected while idle. It stays high for the whole session and falls once the session ends with a command or a drop.
- R4: A slot decodes as 0 if a field stop is declared on any tick of that slot, including its last period (31). Otherwise it decodes as 1.
- R5: The first slot of a session is the start bit. If it decodes as 1, the session ends with a `cmd_drop` pulse and no command.
- R6: The code is three bits, sent with the MSB of `cmd_kind` first, followed by one even parity bit. The valid codes are 001 login, 010 write, 100 read, 110 protect and 101 disable. A parity mismatch or any other code ends the session with `cmd_drop` only.
- R7: After the code, write takes an address field and then a data field, read takes only an address field, and login, protect and disable take only a data field.
- R8: The address field is seven bits: address bit 0 first through bit 3, then two reserved bits that must be 0, then even parity over the four address bits. A parity mismatch or a reserved bit at 1 sets `cmd_err`, and the command is still reported.
- R9: The data field is 45 bits. It holds four rows of eight data bits, starting with `cmd_data[0]`, each row followed by its even parity bit. Then come eight even column parity bits, where column c covers data bits c, c+8, c+16 and c+24, and finally one 0 bit. Any mismatch sets `cmd_err`, and the command is still reported.
- R10: Each session yields exactly one single-cycle pulse, either `cmd_valid` or `cmd_drop` and never both. The command outputs hold their values after `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_tick | input | 1 | One-cycle pulse per RF period |
| field_on | input | 1 | Field present, sampled on each tick |
| busy | output | 1 | Receive session in progress; normal replies suspended |
| mod_on | output | 1 | Modulator engaged (second half of each slot) |
| cmd_valid | output | 1 | One-cycle pulse: decoded command available |
| cmd_drop | output | 1 | One-cycle pulse: session abandoned silently |
| cmd_kind | output | 3 | Command code of the last decoded command |
| cmd_addr | output | 4 | Word address (write and read) |
| cmd_data | output | 32 | Data word (write, login, protect, disable) |
| cmd_err | output | 1 | Address or data parity or format fault in the last command |

## Verification
The bench targets the edges of stop detection. A four-tick dip must be ignored. A stop that completes exactly on the last period of a slot must still count as 0, and a design that samples the bit one tick early would read it as 1 and lose the frame. It flips the code parity, the address parity, a reserved address bit, one row parity, one column parity and the trailing bit, one at a time. Code faults must end silently, while field faults must still report a command with the error flag. A design that mixed these up would either answer garbage or stay mute where an error reply is owed. The `mod_on` phase is checked on both sides of the half-slot boundary, and each command kind is checked to pull exactly its own fields.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int CODE_BITS = 3;
    localparam int ADDR_BITS = 4;
    localparam int RSV_BITS  = 2;
    localparam int ROWS      = 4;
    localparam int ROW_BITS  = 8;
    localparam int DATA_BITS = ROWS * ROW_BITS;

    typedef enum logic [CODE_BITS-1:0] {
        CK_NONE    = 3'b000,
        CK_LOGIN   = 3'b001,
        CK_WRITE   = 3'b010,
        CK_READ    = 3'b100,
        CK_PROTECT = 3'b110,
        CK_DISABLE = 3'b101
    } cmd_kind_e;

    typedef enum logic [1:0] {
        SL_IDLE,
        SL_WAIT,
        SL_RUN
    } slot_state_e;

    typedef enum logic [1:0] {
        PS_START,
        PS_CODE,
        PS_ADDR,
        PS_DATA
    } parse_state_e;

    typedef struct packed {
        cmd_kind_e              kind;
        logic [ADDR_BITS-1:0]   addr;
        logic [DATA_BITS-1:0]   data;
        logic                   err;
    } cmd_t;

    function automatic logic code_known(input logic [CODE_BITS-1:0] c);
        case (c)
            3'b001, 3'b010, 3'b100, 3'b110, 3'b101: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic logic takes_addr(input cmd_kind_e k);
        return (k == CK_WRITE) || (k == CK_READ);
    endfunction

endpackage

// File: rtl/fsr_stop_det.sv
module fsr_stop_det #(
    parameter int STOP_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic rf_tick,
    input  logic field_on,
    output logic stop_evt
);
    localparam int GW = $clog2(STOP_TICKS + 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(STOP_TICKS);
    localparam logic [GW-1:0] GAP_TRIG = GW'(STOP_TICKS - 1);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (rf_tick) begin
            if (field_on)
                gap_q <= '0;
            else if (gap_q != GAP_FULL)
                gap_q <= gap_q + 1'b1;
        end
    end

    assign stop_evt = rf_tick && !field_on && (gap_q == GAP_TRIG);

    AST_STOP_ONCE: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !stop_evt); // R1

endmodule

// File: rtl/fsr_slot.sv
module fsr_slot
    import fsr_pkg::*;
#(
    parameter int SLOT_TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic rf_tick,
    input  logic field_on,
    input  logic stop_evt,
    input  logic quit,
    output logic bit_vld,
    output logic bit_val,
    output logic busy,
    output logic mod_on
);
    localparam int PW = $clog2(SLOT_TICKS);
    localparam logic [PW-1:0] PH_LAST = PW'(SLOT_TICKS - 1);
    localparam logic [PW-1:0] PH_HALF = PW'(SLOT_TICKS / 2);

    slot_state_e   st_q;
    logic [PW-1:0] phase_q;
    logic          zmark_q;
    logic          bvld_q;
    logic          bval_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SL_IDLE;
            phase_q <= '0;
            zmark_q <= 1'b0;
            bvld_q  <= 1'b0;
            bval_q  <= 1'b0;
        end else begin
            bvld_q <= 1'b0;
            case (st_q)
                SL_IDLE: begin
                    if (stop_evt)
                        st_q <= SL_WAIT;
                end
                SL_WAIT: begin
                    if (rf_tick && field_on) begin
                        st_q    <= SL_RUN;
                        phase_q <= '0;
                        zmark_q <= 1'b0;
                    end
                end
                SL_RUN: begin
                    if (quit) begin
                        st_q    <= SL_IDLE;
                        phase_q <= '0;
                        zmark_q <= 1'b0;
                    end else if (rf_tick) begin
                        if (phase_q == PH_LAST) begin
                            phase_q <= '0;
                            zmark_q <= 1'b0;
                            bvld_q  <= 1'b1;
                            bval_q  <= !(zmark_q || stop_evt);
                        end else begin
                            phase_q <= phase_q + 1'b1;
                            zmark_q <= zmark_q || stop_evt;
                        end
                    end
                end
                default: st_q <= SL_IDLE;
            endcase
        end
    end

    assign bit_vld = bvld_q;
    assign bit_val = bval_q;
    assign busy    = (st_q != SL_IDLE);
    assign mod_on  = (st_q == SL_RUN) && (phase_q >= PH_HALF);

    AST_MODON_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rf_tick && !quit) |=> $stable(mod_on)); // R2

endmodule

// File: rtl/fsr_parse.sv
module fsr_parse
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_val,
    output logic fin,
    output logic cmd_valid,
    output logic cmd_drop,
    output cmd_t cmd_o
);
    localparam int CW  = $clog2(ADDR_BITS + RSV_BITS + 1 + 1);
    localparam int RW  = $clog2(ROWS + 1);
    localparam int KW  = $clog2(ROW_BITS + 1);
    localparam int AIW = $clog2(ADDR_BITS);
    localparam int RIW = $clog2(ROWS);
    localparam int CIW = $clog2(ROW_BITS);

    localparam logic [CW-1:0] C_CODE_END = CW'(CODE_BITS);
    localparam logic [CW-1:0] C_ADDR_END = CW'(ADDR_BITS);
    localparam logic [CW-1:0] C_RSV_END  = CW'(ADDR_BITS + RSV_BITS);
    localparam logic [RW-1:0] R_LAST     = RW'(ROWS);
    localparam logic [KW-1:0] K_PAR      = KW'(ROW_BITS);

    parse_state_e          ps_q;
    logic [CW-1:0]         cnt_q;
    logic [CODE_BITS-1:0]  code_q;
    cmd_kind_e             kind_q;
    logic [ADDR_BITS-1:0]  addr_q;
    logic [DATA_BITS-1:0]  data_q;
    logic                  par_q;
    logic                  rowp_q;
    logic [ROW_BITS-1:0]   colp_q;
    logic [RW-1:0]         row_q;
    logic [KW-1:0]         col_q;
    logic                  err_q;
    logic                  valid_q;
    logic                  drop_q;

    logic code_bad;
    logic emit_c;
    logic drop_c;

    always_comb begin
        code_bad = (^{code_q, bit_val}) || !code_known(code_q);
        emit_c   = 1'b0;
        drop_c   = 1'b0;
        if (bit_vld) begin
            case (ps_q)
                PS_START: drop_c = bit_val;
                PS_CODE:  drop_c = (cnt_q == C_CODE_END) && code_bad;
                PS_ADDR:  emit_c = (cnt_q == C_RSV_END) && (kind_q == CK_READ);
                PS_DATA:  emit_c = (row_q == R_LAST) && (col_q == K_PAR);
                default:  ;
            endcase
        end
    end

    assign fin = emit_c || drop_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q    <= PS_START;
            cnt_q   <= '0;
            code_q  <= '0;
            kind_q  <= CK_NONE;
            addr_q  <= '0;
            data_q  <= '0;
            par_q   <= 1'b0;
            rowp_q  <= 1'b0;
            colp_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            err_q   <= 1'b0;
            valid_q <= 1'b0;
            drop_q  <= 1'b0;
        end else begin
            valid_q <= emit_c;
            drop_q  <= drop_c;
            if (bit_vld) begin
                case (ps_q)
                    PS_START: begin
                        if (!bit_val) begin
                            ps_q   <= PS_CODE;
                            cnt_q  <= '0;
                            code_q <= '0;
                            err_q  <= 1'b0;
                        end
                    end
                    PS_CODE: begin
                        if (cnt_q != C_CODE_END) begin
                            code_q <= {code_q[CODE_BITS-2:0], bit_val};
                            cnt_q  <= cnt_q + 1'b1;
                        end else if (code_bad) begin
                            ps_q <= PS_START;
                        end else begin
                            kind_q <= cmd_kind_e'(code_q);
                            cnt_q  <= '0;
                            par_q  <= 1'b0;
                            rowp_q <= 1'b0;
                            colp_q <= '0;
                            row_q  <= '0;
                            col_q  <= '0;
                            addr_q <= '0;
                            data_q <= '0;
                            ps_q   <= takes_addr(cmd_kind_e'(code_q)) ? PS_ADDR : PS_DATA;
                        end
                    end
                    PS_ADDR: begin
                        if (cnt_q < C_ADDR_END) begin
                            addr_q[cnt_q[AIW-1:0]] <= bit_val;
                            par_q <= par_q ^ bit_val;
                            cnt_q <= cnt_q + 1'b1;
                        end else if (cnt_q < C_RSV_END) begin
                            if (bit_val)
                                err_q <= 1'b1;
                            cnt_q <= cnt_q + 1'b1;
                        end else begin
                            if (par_q ^ bit_val)
                                err_q <= 1'b1;
                            cnt_q <= '0;
                            ps_q  <= (kind_q == CK_READ) ? PS_START : PS_DATA;
                        end
                    end
                    PS_DATA: begin
                        if (row_q != R_LAST) begin
                            if (col_q != K_PAR) begin
                                data_q[{row_q[RIW-1:0], col_q[CIW-1:0]}] <= bit_val;
                                rowp_q <= rowp_q ^ bit_val;
                                colp_q[col_q[CIW-1:0]] <= colp_q[col_q[CIW-1:0]] ^ bit_val;
                                col_q <= col_q + 1'b1;
                            end else begin
                                if (rowp_q ^ bit_val)
                                    err_q <= 1'b1;
                                rowp_q <= 1'b0;
                                col_q  <= '0;
                                row_q  <= row_q + 1'b1;
                            end
                        end else begin
                            if (col_q != K_PAR) begin
                                if (colp_q[col_q[CIW-1:0]] ^ bit_val)
                                    err_q <= 1'b1;
                                col_q <= col_q + 1'b1;
                            end else begin
                                if (bit_val)
                                    err_q <= 1'b1;
                                ps_q <= PS_START;
                            end
                        end
                    end
                    default: ps_q <= PS_START;
                endcase
            end
        end
    end

    assign cmd_valid  = valid_q;
    assign cmd_drop   = drop_q;
    assign cmd_o.kind = kind_q;
    assign cmd_o.addr = addr_q;
    assign cmd_o.data = data_q;
    assign cmd_o.err  = err_q;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q); // R10

    AST_KIND_KNOWN: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> code_known(kind_q)); // R6

endmodule

// File: rtl/fsr_cmd_rx.sv
module fsr_cmd_rx
    import fsr_pkg::*;
#(
    parameter int SLOT_TICKS = 32,
    parameter int STOP_TICKS = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rf_tick,
    input  logic                  field_on,
    output logic                  busy,
    output logic                  mod_on,
    output logic                  cmd_valid,
    output logic                  cmd_drop,
    output logic [CODE_BITS-1:0]  cmd_kind,
    output logic [ADDR_BITS-1:0]  cmd_addr,
    output logic [DATA_BITS-1:0]  cmd_data,
    output logic                  cmd_err
);
    logic stop_evt;
    logic bit_vld;
    logic bit_val;
    logic fin;
    cmd_t cmd_w;

    fsr_stop_det #(
        .STOP_TICKS(STOP_TICKS)
    ) u_stop (
        .clk      (clk),
        .rst      (rst),
        .rf_tick  (rf_tick),
        .field_on (field_on),
        .stop_evt (stop_evt)
    );

    fsr_slot #(
        .SLOT_TICKS(SLOT_TICKS)
    ) u_slot (
        .clk      (clk),
        .rst      (rst),
        .rf_tick  (rf_tick),
        .field_on (field_on),
        .stop_evt (stop_evt),
        .quit     (fin),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .busy     (busy),
        .mod_on   (mod_on)
    );

    fsr_parse u_parse (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (bit_vld),
        .bit_val   (bit_val),
        .fin       (fin),
        .cmd_valid (cmd_valid),
        .cmd_drop  (cmd_drop),
        .cmd_o     (cmd_w)
    );

    assign cmd_kind = cmd_w.kind;
    assign cmd_addr = cmd_w.addr;
    assign cmd_data = cmd_w.data;
    assign cmd_err  = cmd_w.err;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_drop)); // R10

    AST_RESULT_IN_SESSION: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || cmd_drop) |-> $past(busy)); // R3

endmodule

// File: tb/fsr_cmd_rx_tb.sv
module fsr_cmd_rx_tb;
    import fsr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rf_tick = 1'b0;
    logic        field_on = 1'b1;
    logic        busy, mod_on, cmd_valid, cmd_drop, cmd_err;
    logic [2:0]  cmd_kind;
    logic [3:0]  cmd_addr;
    logic [31:0] cmd_data;

    always #4 clk = ~clk;

    fsr_cmd_rx u_dut (
        .clk(clk), .rst(rst), .rf_tick(rf_tick), .field_on(field_on),
        .busy(busy), .mod_on(mod_on), .cmd_valid(cmd_valid), .cmd_drop(cmd_drop),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_err(cmd_err)
    );

    localparam logic [3:0] F_NONE = 4'd0, F_START = 4'd1, F_CPAR = 4'd2, F_UNK = 4'd3,
                           F_APAR = 4'd4, F_RSV = 4'd5, F_ROW = 4'd6, F_COL = 4'd7, F_END = 4'd8;

    typedef struct packed {
        logic [2:0]  code;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [3:0]  flt;
        logic        ev;
        logic        ee;
    } vec_t;

    localparam vec_t VEC [14] = '{
        '{3'b100, 4'd5,  32'h0000_0000, F_NONE,  1'b1, 1'b0},
        '{3'b010, 4'd9,  32'hA5C3_0F12, F_NONE,  1'b1, 1'b0},
        '{3'b001, 4'd0,  32'h1234_5678, F_NONE,  1'b1, 1'b0},
        '{3'b110, 4'd0,  32'h0000_7FFF, F_NONE,  1'b1, 1'b0},
        '{3'b101, 4'd0,  32'hFFFF_FFFF, F_NONE,  1'b1, 1'b0},
        '{3'b100, 4'd3,  32'h0000_0000, F_APAR,  1'b1, 1'b1},
        '{3'b010, 4'd2,  32'h0F0F_00FF, F_RSV,   1'b1, 1'b1},
        '{3'b001, 4'd0,  32'hDEAD_BEEF, F_ROW,   1'b1, 1'b1},
        '{3'b110, 4'd0,  32'h0000_1234, F_COL,   1'b1, 1'b1},
        '{3'b101, 4'd0,  32'hFFFF_FFFF, F_END,   1'b1, 1'b1},
        '{3'b100, 4'd7,  32'h0000_0000, F_CPAR,  1'b0, 1'b0},
        '{3'b011, 4'd0,  32'h0000_0000, F_UNK,   1'b0, 1'b0},
        '{3'b001, 4'd0,  32'h0000_0001, F_START, 1'b0, 1'b0},
        '{3'b010, 4'd15, 32'h8000_0001, F_NONE,  1'b1, 1'b0}
    };

    int n_chk = 0;
    int n_err = 0;
    int n_valid = 0;
    int n_drop = 0;
    logic fb [0:127];
    int   fn = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid) n_valid++;
            if (cmd_drop)  n_drop++;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic period(input logic f);
        @(negedge clk); field_on = f; rf_tick = 1'b1;
        @(negedge clk); rf_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic periods(input int n, input logic f);
        for (int i = 0; i < n; i++) period(f);
    endtask

    task automatic send_bit(input logic b);
        if (b) periods(32, 1'b1);
        else begin periods(18, 1'b1); periods(14, 1'b0); end
    endtask

    task automatic push(input logic b);
        fb[fn] = b;
        fn++;
    endtask

    function automatic logic known(input logic [2:0] c);
        return c == 3'b001 || c == 3'b010 || c == 3'b100 || c == 3'b110 || c == 3'b101;
    endfunction

    task automatic build(input logic [2:0] code, input logic [3:0] a, input logic [31:0] d, input logic [3:0] flt);
        fn = 0;
        push(flt == F_START);
        if (flt == F_START) return;
        for (int i = 2; i >= 0; i--) push(code[i]);
        push((^code) ^ (flt == F_CPAR));
        if (flt == F_CPAR || !known(code)) return;
        if (code == 3'b010 || code == 3'b100) begin
            for (int i = 0; i < 4; i++) push(a[i]);
            push(1'b0);
            push(flt == F_RSV);
            push((^a) ^ (flt == F_APAR));
        end
        if (code != 3'b100) begin
            for (int r = 0; r < 4; r++) begin
                for (int k = 0; k < 8; k++) push(d[8*r+k]);
                push((^d[8*r +: 8]) ^ (flt == F_ROW && r == 1));
            end
            for (int c = 0; c < 8; c++)
                push(d[c] ^ d[8+c] ^ d[16+c] ^ d[24+c] ^ (flt == F_COL && c == 3));
            push(flt == F_END);
        end
    endtask

    function automatic string tag_of(input logic [3:0] f);
        case (f)
            F_START:              return "R5";
            F_CPAR, F_UNK:        return "R6";
            F_APAR, F_RSV:        return "R8";
            F_ROW, F_COL, F_END:  return "R9";
            default:              return "R7";
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        int v0, d0;
        string t;
        v0 = n_valid;
        d0 = n_drop;
        t = tag_of(v.flt);
        build(v.code, v.addr, v.data, v.flt);
        periods(10, 1'b0);
        for (int i = 0; i < fn; i++) send_bit(fb[i]);
        periods(40, 1'b1);
        if (v.ev) begin
            chk("R10", "valid pulses", 64'(n_valid - v0), 64'd1);
            chk("R10", "drop pulses", 64'(n_drop - d0), 64'd0);
            chk("R6", "kind", 64'(cmd_kind), 64'(v.code));
            if (v.code == 3'b010 || v.code == 3'b100) chk(t, "addr", 64'(cmd_addr), 64'(v.addr));
            if (v.code != 3'b100) chk(t, "data", 64'(cmd_data), 64'(v.data));
            chk(t, "err", 64'(cmd_err), 64'(v.ee));
        end else begin
            chk(t, "drop pulses", 64'(n_drop - d0), 64'd1);
            chk(t, "valid pulses", 64'(n_valid - v0), 64'd0);
        end
        chk("R3", "busy after session", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R10 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
        $finish;
    end

    initial begin
        int v0, d0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3", "reset busy", 64'(busy), 64'd0);
        chk("R2", "reset mod_on", 64'(mod_on), 64'd0);
        chk("R10", "reset valid", 64'(cmd_valid), 64'd0);
        chk("R10", "reset drop", 64'(cmd_drop), 64'd0);

        for (int i = 0; i < 14; i++) run_vec(VEC[i]);

        // R1: a four-tick dip is ignored; five ticks start a session
        d0 = n_drop;
        periods(4, 1'b0);
        periods(40, 1'b1);
        chk("R1", "busy after short dip", 64'(busy), 64'd0);
        chk("R1", "no drop after short dip", 64'(n_drop - d0), 64'd0);
        periods(5, 1'b0);
        chk("R1", "busy after full stop", 64'(busy), 64'd1);

        // R2: mod_on phase across the half-slot boundary (start bit sent as 1)
        periods(16, 1'b1);
        chk("R2", "mod_on period 15", 64'(mod_on), 64'd0);
        period(1'b1);
        chk("R2", "mod_on period 16", 64'(mod_on), 64'd1);
        periods(15, 1'b1);
        chk("R2", "mod_on period 31", 64'(mod_on), 64'd1);
        period(1'b1);
        periods(2, 1'b1);
        chk("R5", "drop on start bit 1", 64'(n_drop - d0), 64'd1);
        chk("R2", "mod_on after session", 64'(mod_on), 64'd0);
        chk("R3", "busy after drop", 64'(busy), 64'd0);

        // R4: a dip too short inside the start slot reads as 1
        d0 = n_drop;
        periods(10, 1'b0);
        periods(18, 1'b1); periods(4, 1'b0); periods(10, 1'b1);
        periods(10, 1'b1);
        chk("R4", "short dip decodes as 1", 64'(n_drop - d0), 64'd1);

        // R4: stop completing on period 31 still reads as 0
        v0 = n_valid;
        build(3'b100, 4'd6, 32'h0, F_NONE);
        periods(10, 1'b0);
        periods(27, 1'b1); periods(5, 1'b0);
        for (int i = 1; i < fn; i++) send_bit(fb[i]);
        periods(40, 1'b1);
        chk("R4", "late stop decodes as 0", 64'(n_valid - v0), 64'd1);
        chk("R8", "late-stop frame addr", 64'(cmd_addr), 64'd6);
        chk("R8", "late-stop frame err", 64'(cmd_err), 64'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule